// File: doc/BRIEF.md
# Floating-Point Compare Condition Generator

This block compares two IEEE-754 binary floating-point operands and returns a 32-bit condition word in which ten relations are reported at once. Either operand may be single or double precision, chosen per operand. A single-precision operand is widened exactly to double before the compare, so a mixed-precision compare gives the exact mathematical result. Besides the six usual orderings, four bits test where operand 1 lies relative to zero and to operand 2. This lets one compare instruction feed any later conditional branch or select.

An issue strobe marks a compare. The result is captured in one output register, together with the destination index and a write enable. The write enable stays low when the destination index is zero. When the immediate form is used, operand 1 is taken as a 32-bit single-precision value whatever its precision select says.

Top module: `fcmp_cond`

## Requirements
- R1: When `op1_dbl` is 1 and `imm_sel` is 0, operand 1 is the double held in all 64 bits of `op1_bits`. When `op1_dbl` is 0, operand 1 is the single in `op1_bits[31:0]`, and `op1_bits[63:32]` has no effect.
- R2: When `imm_sel` is 1, operand 1 is the single in `op1_bits[31:0]` whatever `op1_dbl` says.
- R3: `op2_dbl` = 1 selects the double in all of `op2_bits`. `op2_dbl` = 0 selects the single in `op2_bits[31:0]`.
- R4: For ordered operands, the following bits are set when their relation holds: bit 20 for op1 == op2, bit 21 for !=, bit 22 for >, bit 23 for <=, bit 24 for <, and bit 25 for >=.
- R5: For ordered operands, bit 26 = (op1 < 0 or op1 > op2), and bit 27 = (0 < op1 < op2).
- R6: For ordered operands, bit 28 = (0 <= op1 <= op2), and bit 29 = (op1 <= 0 or op1 >= op2).
- R7: Bits 0 to 19 and 30 to 31 of `cond_word` are always 0.
- R8: A compare issued with `dst_idx` = 0 gives `cond_we` = 0.
- R9: A single operand is widened exactly, and this includes single denormals. A single and a double of the same value compare equal, and unequal values of different precision are ordered correctly.
- R10: +0 and -0 are equal in every relation, and both count as zero for bits 26 to 29.
- R11: If either operand is a NaN, the word is exactly bit 21 set.
- R12: After reset, `cond_we` and `cond_word` are 0. A compare issued at a clock edge shows its `cond_word`, `cond_we` and `cond_dst` after that same edge. Without an issue, `cond_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | A compare is presented this cycle |
| imm_sel | input | 1 | Operand 1 is a single-precision immediate |
| op1_dbl | input | 1 | Operand 1 precision: 1 = double, 0 = single |
| op2_dbl | input | 1 | Operand 2 precision: 1 = double, 0 = single |
| op1_bits | input | 64 | Raw operand 1 (single in the low 32 bits) |
| op2_bits | input | 64 | Raw operand 2 (single in the low 32 bits) |
| dst_idx | input | DST_W | Destination register index |
| cond_word | output | 32 | Registered condition word |
| cond_we | output | 1 | Result write enable |
| cond_dst | output | DST_W | Registered destination index |

## Verification
Each result is due exactly one rising edge after the compare is presented. The bench drives every stimulus on a falling edge and samples the outputs on the next falling edge, so each check sees the result of that stimulus only. The bench's expected word comes from the operand values rebuilt as reals, with NaN flagged from the bit fields. It is compared on every stimulus, including cycles with no issue or with a zero destination, where only the write enable is judged.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    localparam int SP_EXP_W  = 8;
    localparam int SP_FRAC_W = 23;
    localparam int DP_EXP_W  = 11;
    localparam int DP_FRAC_W = 52;
    localparam int SP_BIAS   = 127;
    localparam int DP_BIAS   = 1023;
    localparam int COND_W    = 32;

    // single normal exponent -> double exponent
    localparam int EXP_SHIFT  = DP_BIAS - SP_BIAS;
    // biased double exponent of a single denormal whose leading one is at bit 0
    localparam int DENORM_EXP = DP_BIAS - (SP_BIAS - 1) - SP_FRAC_W;
    localparam int FRAC_PAD   = DP_FRAC_W - SP_FRAC_W;

    // condition bit positions (decoded by later conditional instructions)
    localparam int CB_EQ   = 20;
    localparam int CB_NE   = 21;
    localparam int CB_GT   = 22;
    localparam int CB_LE   = 23;
    localparam int CB_LT   = 24;
    localparam int CB_GE   = 25;
    localparam int CB_OUT  = 26;
    localparam int CB_INX  = 27;
    localparam int CB_INC  = 28;
    localparam int CB_OUTC = 29;

    typedef struct packed {
        logic                 sign;
        logic [DP_EXP_W-1:0]  exp;
        logic [DP_FRAC_W-1:0] frac;
    } dbl_t;

    typedef struct packed {
        logic unord;   // at least one NaN
        logic eq;
        logic lt;
        logic a_neg;   // op1 strictly below zero
        logic a_zero;  // op1 is +0 or -0
    } rel_t;

    function automatic logic [4:0] lead_one(input logic [SP_FRAC_W-1:0] m);
        logic [4:0] p;
        p = '0;
        for (int i = 0; i < SP_FRAC_W; i++)
            if (m[i]) p = 5'(i);
        return p;
    endfunction

endpackage

// File: rtl/fcmp_widen.sv
module fcmp_widen
    import fcmp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [63:0] raw,
    input  logic        is_dbl,
    output dbl_t        wide,
    output logic        is_zero,
    output logic        is_nan
);
    logic [SP_EXP_W-1:0]  sp_e;
    logic [SP_FRAC_W-1:0] sp_f;
    logic [4:0]           lp;
    logic [DP_FRAC_W:0]   sh;

    always_comb begin
        sp_e = raw[30:23];
        sp_f = raw[22:0];
        lp   = lead_one(sp_f);
        sh   = {{(DP_FRAC_W-SP_FRAC_W+1){1'b0}}, sp_f} << (6'd52 - {1'b0, lp});
        wide = '0;
        if (is_dbl) begin
            wide = dbl_t'(raw);
        end else begin
            wide.sign = raw[31];
            if (sp_e == '1) begin
                wide.exp  = '1;
                wide.frac = {sp_f, {FRAC_PAD{1'b0}}};
            end else if (sp_e == '0) begin
                if (sp_f != '0) begin
                    wide.exp  = DP_EXP_W'(DENORM_EXP) + {6'b0, lp};
                    wide.frac = sh[DP_FRAC_W-1:0];
                end
            end else begin
                wide.exp  = {3'b0, sp_e} + DP_EXP_W'(EXP_SHIFT);
                wide.frac = {sp_f, {FRAC_PAD{1'b0}}};
            end
        end
        is_zero = (wide.exp == '0) && (wide.frac == '0);
        is_nan  = (wide.exp == '1) && (wide.frac != '0);
    end

    a_r11_single_nan_kept: assert property (@(posedge clk) disable iff (rst)
        (!is_dbl && raw[30:23] == 8'hFF && raw[22:0] != '0) |-> is_nan);
    a_r10_single_zero_kept: assert property (@(posedge clk) disable iff (rst)
        (!is_dbl && raw[30:0] == '0) |-> (is_zero && wide.sign == raw[31]));
    a_r9_denorm_normalised: assert property (@(posedge clk) disable iff (rst)
        (!is_dbl && raw[30:23] == '0 && raw[22:0] != '0) |-> (wide.exp != '0 && !is_zero));

endmodule

// File: rtl/fcmp_relate.sv
module fcmp_relate
    import fcmp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  dbl_t a,
    input  dbl_t b,
    input  logic a_zero,
    input  logic b_zero,
    input  logic a_nan,
    input  logic b_nan,
    output rel_t rel
);
    logic [DP_EXP_W+DP_FRAC_W-1:0] mag_a, mag_b;
    logic mag_lt, mag_eq, both_zero, unord;

    always_comb begin
        mag_a     = {a.exp, a.frac};
        mag_b     = {b.exp, b.frac};
        mag_lt    = mag_a < mag_b;
        mag_eq    = mag_a == mag_b;
        unord     = a_nan | b_nan;
        both_zero = a_zero & b_zero;

        rel        = '0;
        rel.unord  = unord;
        rel.a_zero = a_zero;
        rel.a_neg  = a.sign & ~a_zero & ~a_nan;
        if (!unord) begin
            if (both_zero) begin
                rel.eq = 1'b1;
            end else if (a.sign != b.sign) begin
                rel.lt = a.sign;
            end else begin
                rel.eq = mag_eq;
                rel.lt = a.sign ? (~mag_lt & ~mag_eq) : mag_lt;
            end
        end
    end

    a_r4_eq_excludes_lt: assert property (@(posedge clk) disable iff (rst)
        rel.eq |-> !rel.lt);
    a_r10_zeros_equal: assert property (@(posedge clk) disable iff (rst)
        (a_zero && b_zero) |-> (rel.eq && !rel.a_neg));
    a_r11_nan_unordered: assert property (@(posedge clk) disable iff (rst)
        (a_nan || b_nan) |-> (!rel.eq && !rel.lt));

endmodule

// File: rtl/fcmp_pack.sv
module fcmp_pack
    import fcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  rel_t              rel,
    output logic [COND_W-1:0] word
);
    logic gt, a_pos;

    always_comb begin
        gt    = ~rel.eq & ~rel.lt;
        a_pos = ~rel.a_neg & ~rel.a_zero;
        word  = '0;
        if (rel.unord) begin
            word[CB_NE] = 1'b1;
        end else begin
            word[CB_EQ]   = rel.eq;
            word[CB_NE]   = ~rel.eq;
            word[CB_GT]   = gt;
            word[CB_LE]   = ~gt;
            word[CB_LT]   = rel.lt;
            word[CB_GE]   = ~rel.lt;
            word[CB_OUT]  = rel.a_neg | gt;
            word[CB_INX]  = a_pos & rel.lt;
            word[CB_INC]  = ~rel.a_neg & ~gt;
            word[CB_OUTC] = ~a_pos | ~rel.lt;
        end
    end

    a_r11_nan_only_ne: assert property (@(posedge clk) disable iff (rst)
        rel.unord |-> (word == (32'd1 << CB_NE)));
    a_r6_closed_range_in_le: assert property (@(posedge clk) disable iff (rst)
        word[CB_INC] |-> (word[CB_LE] && !word[CB_GT]));

endmodule

// File: rtl/fcmp_cond.sv
module fcmp_cond
    import fcmp_pkg::*;
#(
    parameter int DST_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  logic              imm_sel,
    input  logic              op1_dbl,
    input  logic              op2_dbl,
    input  logic [63:0]       op1_bits,
    input  logic [63:0]       op2_bits,
    input  logic [DST_W-1:0]  dst_idx,
    output logic [COND_W-1:0] cond_word,
    output logic              cond_we,
    output logic [DST_W-1:0]  cond_dst
);
    localparam int NOPS = 2;

    logic [63:0] raw_sel [NOPS];
    logic        dbl_sel [NOPS];
    dbl_t        wide    [NOPS];
    logic        zero_f  [NOPS];
    logic        nan_f   [NOPS];
    rel_t        rel;
    logic [COND_W-1:0] word_d;

    always_comb begin
        raw_sel[0] = op1_bits;
        dbl_sel[0] = op1_dbl & ~imm_sel;
        raw_sel[1] = op2_bits;
        dbl_sel[1] = op2_dbl;
    end

    for (genvar i = 0; i < NOPS; i++) begin : g_widen
        fcmp_widen u_widen (
            .clk    (clk),
            .rst    (rst),
            .raw    (raw_sel[i]),
            .is_dbl (dbl_sel[i]),
            .wide   (wide[i]),
            .is_zero(zero_f[i]),
            .is_nan (nan_f[i])
        );
    end

    fcmp_relate u_relate (
        .clk   (clk),
        .rst   (rst),
        .a     (wide[0]),
        .b     (wide[1]),
        .a_zero(zero_f[0]),
        .b_zero(zero_f[1]),
        .a_nan (nan_f[0]),
        .b_nan (nan_f[1]),
        .rel   (rel)
    );

    fcmp_pack u_pack (
        .clk (clk),
        .rst (rst),
        .rel (rel),
        .word(word_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_word <= '0;
            cond_we   <= 1'b0;
            cond_dst  <= '0;
        end else begin
            cond_we <= issue && (dst_idx != '0);
            if (issue) begin
                cond_word <= word_d;
                cond_dst  <= dst_idx;
            end
        end
    end

    a_r8_dst_zero_no_write: assert property (@(posedge clk) disable iff (rst)
        (issue && dst_idx == '0) |=> !cond_we);
    a_r12_write_needs_issue: assert property (@(posedge clk) disable iff (rst)
        cond_we |-> $past(issue));
    a_r4_orderings_exclusive: assert property (@(posedge clk) disable iff (rst)
        cond_we |-> ($countones({cond_word[CB_EQ], cond_word[CB_GT], cond_word[CB_LT]}) <= 1));
    a_r5_open_range_implies_lt: assert property (@(posedge clk) disable iff (rst)
        (cond_we && cond_word[CB_INX]) |-> (cond_word[CB_LT] && cond_word[CB_INC]));
    a_r7_reserved_stay_zero: assert property (@(posedge clk) disable iff (rst)
        cond_we |-> (cond_word[19:0] == '0 && cond_word[31:30] == '0));

endmodule

// File: tb/fcmp_cond_bench.sv
`timescale 1ns/1ps
module fcmp_cond_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue = 1'b0, imm_sel = 1'b0, op1_dbl = 1'b0, op2_dbl = 1'b0;
    logic [63:0] op1_bits = '0, op2_bits = '0;
    logic [4:0]  dst_idx = '0;
    logic [31:0] cond_word;
    logic        cond_we;
    logic [4:0]  cond_dst;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    fcmp_cond #(.DST_W(5)) u_fcmp_cond (
        .clk(clk), .rst(rst), .issue(issue), .imm_sel(imm_sel),
        .op1_dbl(op1_dbl), .op2_dbl(op2_dbl), .op1_bits(op1_bits),
        .op2_bits(op2_bits), .dst_idx(dst_idx), .cond_word(cond_word),
        .cond_we(cond_we), .cond_dst(cond_dst)
    );

    function automatic real pow2(int n);
        real r = 1.0;
        if (n >= 0) for (int i = 0; i < n; i++) r = r * 2.0;
        else        for (int i = 0; i < -n; i++) r = r / 2.0;
        return r;
    endfunction

    function automatic real sp_val(logic [31:0] w);
        real v;
        int  e = int'(w[30:23]);
        int  f = int'(w[22:0]);
        if (e == 255)    v = $bitstoreal(64'h7FF0000000000000);
        else if (e == 0) v = real'(f) * pow2(-149);
        else             v = real'(f + 8388608) * pow2(e - 150);
        return w[31] ? -v : v;
    endfunction

    function automatic bit is_nan(logic [63:0] w, bit dbl);
        if (dbl) return (w[62:52] == 11'h7FF) && (w[51:0] != 0);
        return (w[30:23] == 8'hFF) && (w[22:0] != 0);
    endfunction

    function automatic real op_val(logic [63:0] w, bit dbl);
        return dbl ? $bitstoreal(w) : sp_val(w[31:0]);
    endfunction

    function automatic logic [31:0] model(real a, real b, bit nan);
        logic [31:0] m = '0;
        if (nan) begin m[21] = 1; return m; end
        m[20] = (a == b);
        m[21] = (a != b);
        m[22] = (a > b);
        m[23] = (a <= b);
        m[24] = (a < b);
        m[25] = (a >= b);
        m[26] = (a < 0.0) || (a > b);
        m[27] = (a > 0.0) && (a < b);
        m[28] = (a >= 0.0) && (a <= b);
        m[29] = (a <= 0.0) || (a >= b);
        return m;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp, string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // drive on a falling edge, sample at the next falling edge
    task automatic apply(string req, bit iss, bit imm, bit d1, bit d2,
                         logic [63:0] a, logic [63:0] b, logic [4:0] dst);
        bit a_dbl = d1 && !imm;
        logic [31:0] ew;
        bit ewe;
        issue = iss; imm_sel = imm; op1_dbl = d1; op2_dbl = d2;
        op1_bits = a; op2_bits = b; dst_idx = dst;
        ew  = model(op_val(a, a_dbl), op_val(b, d2), is_nan(a, a_dbl) || is_nan(b, d2));
        ewe = iss && (dst != 0);
        @(negedge clk);
        check(req, 64'(cond_we), 64'(ewe), "cond_we");
        if (ewe) begin
            check(req, 64'(cond_word), 64'(ew), "cond_word");
            check(req, 64'(cond_dst), 64'(dst), "cond_dst");
        end
    endtask

    function automatic logic [63:0] pick(bit dbl);
        logic [63:0] r = {$urandom, $urandom};
        int k = int'($urandom % 8);
        logic s = r[63];
        if (dbl) begin
            case (k)
                0: r = {s, 63'b0};
                1: r = {s, 11'h7FF, 52'b0};
                2: r = {s, 11'h7FF, 20'h1, r[31:0]};
                3: r = {s, 11'b0, r[51:0]};
                4: r = {s, 11'h3FF - 11'(r[1:0]), 52'b0};
                default: ;
            endcase
        end else begin
            case (k)
                0: r[31:0] = {s, 31'b0};
                1: r[31:0] = {s, 8'hFF, 23'b0};
                2: r[31:0] = {s, 8'hFF, 3'b1, r[19:0]};
                3: r[31:0] = {s, 8'b0, r[22:0]};
                4: r[31:0] = {s, 8'h7F - 8'(r[1:0]), 23'b0};
                default: ;
            endcase
        end
        return r;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #4000000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12", 64'(cond_we), 64'd0, "reset cond_we");
        check("R12", 64'(cond_word), 64'd0, "reset cond_word");
        rst = 1'b0;
        @(negedge clk);
        // R12 no issue -> no write
        apply("R12", 0, 0, 0, 0, 64'h3F800000, 64'h3F800000, 5'd3);
        // R4 equal singles; R1 upper half ignored for single
        apply("R4", 1, 0, 0, 0, 64'hDEADBEEF_3F800000, 64'h3F800000, 5'd1);
        apply("R1", 1, 0, 0, 0, 64'h12345678_40000000, 64'h3F800000, 5'd2);
        // R1 double operand 1, R3 double operand 2
        apply("R1", 1, 0, 1, 1, 64'hBFF0000000000000, 64'h3FF0000000000000, 5'd4);
        apply("R3", 1, 0, 0, 1, 64'h3F000000, 64'h4000000000000000, 5'd5);
        // R2 immediate forces single although op1_dbl=1
        apply("R2", 1, 1, 1, 0, 64'hFFFFFFFF_3F800000, 64'h3F800000, 5'd6);
        // R9 exact widening: single 1.0 == double 1.0; 1+2^-23 > 1+2^-52
        apply("R9", 1, 0, 0, 1, 64'h3F800000, 64'h3FF0000000000000, 5'd7);
        apply("R9", 1, 0, 0, 1, 64'h3F800001, 64'h3FF0000000000001, 5'd8);
        // R9 smallest single denormal equals double 2^-149
        apply("R9", 1, 0, 0, 1, 64'h00000001, 64'h36A0000000000000, 5'd9);
        // R10 signed zeros
        apply("R10", 1, 0, 0, 0, 64'h80000000, 64'h00000000, 5'd10);
        apply("R10", 1, 0, 1, 0, 64'h8000000000000000, 64'h80000000, 5'd11);
        // R5 / R6 range tests: 0<0.5<1, op1 negative, op1 above
        apply("R5", 1, 0, 0, 0, 64'h3F000000, 64'h3F800000, 5'd12);
        apply("R5", 1, 0, 0, 0, 64'hBF000000, 64'h3F800000, 5'd13);
        apply("R6", 1, 0, 0, 0, 64'h40000000, 64'h3F800000, 5'd14);
        apply("R6", 1, 0, 0, 0, 64'h3F800000, 64'h3F800000, 5'd15);
        // R11 NaN in either operand
        apply("R11", 1, 0, 0, 0, 64'h7FC00000, 64'h3F800000, 5'd16);
        apply("R11", 1, 0, 0, 1, 64'h3F800000, 64'h7FF8000000000000, 5'd17);
        // R8 zero destination
        apply("R8", 1, 0, 0, 0, 64'h3F800000, 64'h40000000, 5'd0);
        // infinities, R4
        apply("R4", 1, 0, 0, 1, 64'hFF800000, 64'hFFF0000000000000, 5'd18);
        // random mix: R7 checked through the full word compare
        for (int i = 0; i < 3000; i++) begin
            bit d1 = 1'($urandom);
            bit d2 = 1'($urandom);
            bit im = ($urandom % 6) == 0;
            apply("R7", ($urandom % 8) != 0, im, d1, d2, pick(d1 && !im), pick(d2),
                  5'($urandom % 4));
        end
        finish_run();
    end

endmodule